// File: doc/BRIEF.md
# FIFO Fill Level Status Monitor

This block sits beside an eight-entry elastic FIFO and turns its two pointers into a fill-level report for software. Each time the read pointer is at zero and the pointer pair is marked valid, the block takes the write pointer as the current fill level. It keeps that level in a register and presents it as a 7-bit thermometer code, so the level can be read at any moment without decoding a binary count.

The block also keeps a sticky warning flag. The flag is set whenever a captured level is one slot from empty (level 1) or one slot from full (level 7). It stays set until software clears it. The flag is bit 7 of the status word, above the seven thermometer bits. An interrupt enable gates the flag onto a level-sensitive interrupt line.

The asynchronous active-low reset is released synchronously inside the block, two clock edges after the reset input rises. Register-bus decoding and pointer generation are outside the block.

Top module: `fifo_level_monitor`

## Requirements
- R1: On a clock edge where `ptr_vld` is 1 and `rd_ptr` equals 0, the stored level becomes the value of `wr_ptr`. It shows on `status` after that edge.
- R2: On an edge where `ptr_vld` is 0 or `rd_ptr` is nonzero, `status[6:0]` keeps its value whatever `wr_ptr` carries.
- R3: `status[6:0]` is a thermometer code of the stored level L: bit i is 1 exactly when i < L. Level 0 reads 0000000, level 4 reads 0001111 and level 7 reads 1111111.
- R4: A capture of level 1 or level 7 sets the warning flag on the same edge that updates the level.
- R5: Once set, the warning flag stays set while `warn_clr` is 0, even when later captures hold levels 2 to 6 or 0.
- R6: The warning flag clears on an edge where `warn_clr` is 1. If the same edge also captures level 1 or 7, the flag is set instead.
- R7: The warning flag is `status[7]`.
- R8: `irq` equals `status[7]` AND `irq_en`, combinationally. `irq_en` has no effect on `status`.
- R9: While reset is active, and until the first capture after it, `status` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the FIFO read side |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_ptr | input | 3 | FIFO write pointer |
| rd_ptr | input | 3 | FIFO read pointer |
| ptr_vld | input | 1 | Pointer pair is valid this cycle |
| irq_en | input | 1 | Interrupt enable for the warning flag |
| warn_clr | input | 1 | Software clear of the sticky warning flag |
| status | output | 8 | {warning flag, 7-bit thermometer level} |
| irq | output | 1 | Interrupt request |

## Verification
The checker tests these properties on every cycle:
- the capture rule and the hold rule;
- the shape of the thermometer code;
- warning set on levels 1 and 7, its stickiness, and its clear;
- the gating of the interrupt.

Only the bench's scenarios can show the following:
- the exact codes for levels 0, 4 and 7;
- set taking priority when a clear and a capture of level 1 or 7 fall on the same edge;
- the reset state surviving the synchronous release;
- the level staying put while `wr_ptr` moves with no qualifying capture.

A long stretch of random pointer traffic is then compared against a behavioural model cycle by cycle.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;
  localparam int unsigned LVL_PTR_W_DEF = 3;

  // Near-empty / near-full test for a level in a FIFO of depth 2**ptr_w
  function automatic logic lvl_at_edge(input int unsigned lvl, input int unsigned ptr_w);
    int unsigned depth;
    depth = 1 << ptr_w;
    return (lvl == 1) || (lvl == depth - 1);
  endfunction
endpackage

// File: rtl/lvl_rst_sync.sv
module lvl_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/lvl_capture.sv
module lvl_capture #(
  parameter int unsigned PTR_W = fifo_lvl_pkg::LVL_PTR_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic             ptr_vld,
  output logic             cap_o,
  output logic [PTR_W-1:0] level_o
);
  logic [PTR_W-1:0] level_q, level_d;
  logic             cap;

  always_comb begin
    cap     = ptr_vld && (rd_ptr == '0);
    level_d = level_q;
    if (cap) level_d = wr_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   level_q <= '0;
    else if (cap) level_q <= level_d;
  end

  assign cap_o   = cap;
  assign level_o = level_q;
endmodule

// File: rtl/lvl_therm_enc.sv
module lvl_therm_enc #(
  parameter int unsigned PTR_W   = fifo_lvl_pkg::LVL_PTR_W_DEF,
  localparam int unsigned THERM_W = (1 << PTR_W) - 1
) (
  input  logic [PTR_W-1:0]   level,
  output logic [THERM_W-1:0] therm
);
  for (genvar i = 0; i < THERM_W; i++) begin : g_bit
    assign therm[i] = (32'(level) > i);
  end
endmodule

// File: rtl/lvl_warn.sv
module lvl_warn #(
  parameter int unsigned PTR_W = fifo_lvl_pkg::LVL_PTR_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [PTR_W-1:0] cap_val,
  input  logic             clr,
  output logic             warn_o
);
  logic warn_q, warn_d, hit;

  always_comb begin
    hit    = cap && fifo_lvl_pkg::lvl_at_edge(32'(cap_val), PTR_W);
    warn_d = warn_q;
    if (clr) warn_d = 1'b0;
    if (hit) warn_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warn_q <= 1'b0;
    else        warn_q <= warn_d;
  end

  assign warn_o = warn_q;
endmodule

// File: rtl/fifo_level_monitor.sv
module fifo_level_monitor #(
  parameter int unsigned PTR_W   = fifo_lvl_pkg::LVL_PTR_W_DEF,
  localparam int unsigned THERM_W = (1 << PTR_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic             ptr_vld,
  input  logic             irq_en,
  input  logic             warn_clr,
  output logic [THERM_W:0] status,
  output logic             irq
);
  logic               rst_int_n;
  logic               cap;
  logic [PTR_W-1:0]   level;
  logic [THERM_W-1:0] therm;
  logic               warn;

  lvl_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  lvl_capture #(.PTR_W(PTR_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .ptr_vld (ptr_vld),
    .cap_o   (cap),
    .level_o (level)
  );

  lvl_therm_enc #(.PTR_W(PTR_W)) u_enc (
    .level (level),
    .therm (therm)
  );

  lvl_warn #(.PTR_W(PTR_W)) u_warn (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cap     (cap),
    .cap_val (wr_ptr),
    .clr     (warn_clr),
    .warn_o  (warn)
  );

  assign status = {warn, therm};
  assign irq    = warn & irq_en;
endmodule

// File: rtl/fifo_level_monitor_chk.sv
module fifo_level_monitor_chk #(
  parameter int unsigned PTR_W   = fifo_lvl_pkg::LVL_PTR_W_DEF,
  localparam int unsigned THERM_W = (1 << PTR_W) - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [PTR_W-1:0] rd_ptr,
  input logic             ptr_vld,
  input logic             irq_en,
  input logic             warn_clr,
  input logic [THERM_W:0] status,
  input logic             irq
);
  logic cap_c, edge_c;
  assign cap_c  = ptr_vld && (rd_ptr == '0);
  assign edge_c = cap_c && ((wr_ptr == PTR_W'(1)) || (wr_ptr == PTR_W'(THERM_W)));

  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_c |=> ($countones(status[THERM_W-1:0]) == 32'($past(wr_ptr))));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_c |=> $stable(status[THERM_W-1:0]));

  p_therm_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((status[THERM_W-1:0] & (status[THERM_W-1:0] + 1'b1)) == '0));

  p_warn_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_c |=> status[THERM_W]);

  p_warn_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[THERM_W] && !warn_clr) |=> status[THERM_W]);

  p_warn_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_clr && !edge_c) |=> !status[THERM_W]);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (status[THERM_W] && irq_en));
endmodule

bind fifo_level_monitor fifo_level_monitor_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .wr_ptr   (wr_ptr),
  .rd_ptr   (rd_ptr),
  .ptr_vld  (ptr_vld),
  .irq_en   (irq_en),
  .warn_clr (warn_clr),
  .status   (status),
  .irq      (irq)
);

// File: tb/fifo_level_monitor_tb.sv
`timescale 1ns/1ps
module fifo_level_monitor_tb;
  logic       clk;
  logic       rst_n;
  logic [2:0] wr_ptr, rd_ptr;
  logic       ptr_vld, irq_en, warn_clr;
  logic [7:0] status;
  logic       irq;

  int checks, failures;
  int m_level;
  bit m_warn;

  fifo_level_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .ptr_vld(ptr_vld), .irq_en(irq_en), .warn_clr(warn_clr),
    .status(status), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] expect_status(int lvl, bit w);
    logic [6:0] t;
    t = 7'((1 << lvl) - 1);
    return {w, t};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check({tag, " R1 R3 level"}, {1'b0, status[6:0]}, {1'b0, expect_status(m_level, 1'b0)});
    check({tag, " R7 warn"}, {7'd0, status[7]}, {7'd0, m_warn});
    check({tag, " R8 irq"}, {7'd0, irq}, {7'd0, m_warn & irq_en});
  endtask

  // One cycle: drive at negedge, update model at posedge, check after it
  task automatic step(input int w, input int r, input bit v, input bit en, input bit clr, input string tag);
    bit cap;
    @(negedge clk);
    wr_ptr = 3'(w); rd_ptr = 3'(r); ptr_vld = v; irq_en = en; warn_clr = clr;
    @(posedge clk);
    cap = v && (r == 0);
    if (clr) m_warn = 1'b0;
    if (cap && (w == 1 || w == 7)) m_warn = 1'b1;
    if (cap) m_level = w;
    #2;
    compare(tag);
  endtask

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; m_level = 0; m_warn = 1'b0;
    rst_n = 1'b0; wr_ptr = 3'd7; rd_ptr = 3'd0; ptr_vld = 1'b1; irq_en = 1'b1; warn_clr = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R9 reset status", status, 8'h00);
    check("R9 reset irq", {7'd0, irq}, 8'h00);
    @(negedge clk);
    ptr_vld = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    compare("R9 after release");

    step(4, 0, 1, 0, 0, "R1 cap4");
    check("R3 level4 code", status, 8'b0000_1111);
    step(6, 3, 1, 0, 0, "R2 rd nonzero");
    step(5, 0, 0, 0, 0, "R2 vld low");
    check("R2 held", status, 8'b0000_1111);
    step(0, 0, 1, 0, 0, "R1 cap0");
    check("R3 level0 code", status, 8'h00);
    step(7, 0, 1, 0, 0, "R4 cap7");
    check("R3 R4 R7 level7 code", status, 8'hFF);
    check("R8 irq off", {7'd0, irq}, 8'h00);
    step(7, 2, 0, 1, 0, "R8 irq on");
    check("R8 irq on value", {7'd0, irq}, 8'h01);
    step(3, 0, 1, 1, 0, "R5 sticky");
    check("R5 warn kept", status, 8'b1000_0111);
    step(2, 0, 1, 1, 1, "R6 clear");
    check("R6 warn cleared", status, 8'b0000_0011);
    step(1, 0, 1, 1, 1, "R6 set wins");
    check("R6 R4 set beats clear", status, 8'b1000_0001);
    step(5, 0, 1, 0, 1, "R6 clear2");
    step(1, 0, 1, 1, 0, "R4 cap1");
    check("R4 near empty", status, 8'b1000_0001);

    for (int i = 0; i < 400; i++) begin
      int w, r;
      bit v, en, clr;
      w = $urandom_range(0, 7);
      r = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(0, 7);
      v = ($urandom_range(0, 3) != 0);
      en = $urandom_range(0, 1);
      clr = ($urandom_range(0, 9) == 0);
      step(w, r, v, en, clr, "R1 R2 R5 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule